// File: doc/BRIEF.md
# Black-Level Offset Servo

This block holds the black level of an imaging front end at a programmed target. It drives two offset DAC codes: a 9-bit coarse code and a 10-bit fine code. Digitized pixels count as optical-black samples only when a line-rate calibration strobe is at its active level. The active level is chosen by a polarity input. Each accepted sample is clipped to a ceiling and added to a running sum. The sum can span as many lines as it takes to reach a power-of-two sample count. The average is then compared with the target. The error moves either the coarse code by one step or the fine code by a quarter of the error.

The new codes take effect only while the strobe is active, which is black-pixel time. After an update the sum is cleared, and the loop lets a programmed number of strobe intervals go by before the next pass starts. A manual mode stops the loop and loads both codes straight from register inputs. The analog DACs, the ADC, the register bus and the pixel clocks all lie outside this block.

Top module: `blackLevelServo`

## Requirements
- R1: After reset the coarse code is 256, the fine code is 512, and the loop starts collecting samples.
- R2: A pixel is taken as a sample only on a clock edge where pixValid is 1 and calStrobe equals calPolarity (1 = strobe active high, 0 = active low). All other pixels leave the codes unaffected.
- R3: Each sample is limited to clipCeiling before it is summed.
- R4: One pass sums 2^(avgSel+3) samples (8 to 1024), continuing across strobe intervals as needed. The average is the sum shifted right by avgSel+3.
- R5: With diff = average − target, the coarse code moves if diff ≠ 0 and |diff| ≥ coarseThresh. It moves down by 1 when diff > 0 and up by 1 when diff < 0, saturating at 0 and 511, and the fine code is unchanged.
- R6: Otherwise fine becomes fine − floor(diff/4), rounded toward minus infinity and clamped to 0..1023, and the coarse code is unchanged.
- R7: Take the clock edge that accepts the last sample of a pass. If the strobe is active two edges later, the new codes appear on that edge. Otherwise they appear on the first later edge at which the strobe is active.
- R8: After an update the sum restarts from zero. Strobe intervals end at the edge where the strobe turns inactive. The end of the interval that carried the update is boundary 0, and sampling resumes after boundary waitLines. With waitLines = 0, sampling resumes on the very next interval.
- R9: While manualMode is 1, each clock edge loads coarseCode from manCoarse and fineCode from manFine, and no samples are taken. On exit the loaded codes are kept and a new pass starts from an empty sum.
- R10: Outside an update (R7) or a manual load (R9) both codes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | A digitized pixel is present on pixData |
| pixData | input | 12 | Digitized pixel value |
| calStrobe | input | 1 | Line-rate calibration strobe marking black pixels |
| calPolarity | input | 1 | Active level of calStrobe |
| manualMode | input | 1 | 1 = codes loaded from manCoarse/manFine |
| manCoarse | input | 9 | Manual coarse code |
| manFine | input | 10 | Manual fine code |
| avgSel | input | 3 | Sample count select, 2^(avgSel+3) |
| waitLines | input | 12 | Strobe intervals skipped between passes |
| clipCeiling | input | 12 | Upper limit applied to each sample |
| targetLevel | input | 12 | Target black level |
| coarseThresh | input | 12 | Error magnitude that selects a coarse step |
| coarseCode | output | 9 | Coarse offset DAC code |
| fineCode | output | 10 | Fine offset DAC code |

## Verification
Black lines at levels swept from 0 to 270 in steps of 9 drive the error through both signs and across the coarse threshold. Directed levels at errors of ±1, ±5, and exactly on or just under the threshold pin down the floor rounding and the coarse/fine boundary. Lines of 8, 9 and 10 active pixels separate an update that lands inside the line from one held over to the next strobe interval. Line lengths below the sample count show averaging across lines. Other runs use clipped pixels, masked and out-of-strobe pixels, the opposite strobe polarity, non-zero wait counts, and manual loads at the code limits. Each run tells apart one ignored input, mis-timed update or missing saturation.

// File: rtl/blackcal_pkg.sv
package blackcal_pkg;
  typedef struct packed {
    logic accept;
    logic clearSum;
    logic latchPend;
    logic apply;
    logic loadManual;
  } calCtl_t;

  typedef enum logic [1:0] {
    ST_AVG  = 2'd0,
    ST_CALC = 2'd1,
    ST_PEND = 2'd2,
    ST_WAIT = 2'd3
  } calState_t;
endpackage

// File: rtl/blackcal_ctrl.sv
module blackcal_ctrl
  import blackcal_pkg::*;
#(
  parameter int AVG_W  = 3,
  parameter int WAIT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calStrobe,
  input  logic              calPolarity,
  input  logic              pixValid,
  input  logic              manualMode,
  input  logic [AVG_W-1:0]  avgSel,
  input  logic [WAIT_W-1:0] waitLines,
  output calCtl_t           ctl
);
  localparam int MAX_SHIFT = (1 << AVG_W) - 1 + 3;
  localparam int CNT_W     = MAX_SHIFT + 1;

  calState_t         state;
  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W-1:0]  sampleTarget;
  logic [WAIT_W-1:0] lineCnt;
  logic              active;
  logic              activeQ;
  logic              lineEnd;
  logic              lastSample;

  assign active       = calPolarity ? calStrobe : ~calStrobe;
  assign lineEnd      = activeQ & ~active;
  assign sampleTarget = CNT_W'(1) << (32'(avgSel) + 32'd3);
  assign lastSample   = (sampleCnt + CNT_W'(1)) >= sampleTarget;

  always_comb begin
    ctl = '0;
    if (manualMode) begin
      ctl.loadManual = 1'b1;
      ctl.clearSum   = 1'b1;
    end else begin
      unique case (state)
        ST_AVG:  ctl.accept    = active & pixValid;
        ST_CALC: ctl.latchPend = 1'b1;
        ST_PEND: begin
          ctl.apply    = active;
          ctl.clearSum = active;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_AVG;
      sampleCnt <= '0;
      lineCnt   <= '0;
      activeQ   <= 1'b0;
    end else begin
      activeQ <= active;
      if (manualMode) begin
        state     <= ST_AVG;
        sampleCnt <= '0;
        lineCnt   <= '0;
      end else begin
        unique case (state)
          ST_AVG: if (ctl.accept) begin
            if (lastSample) begin
              sampleCnt <= '0;
              state     <= ST_CALC;
            end else begin
              sampleCnt <= sampleCnt + CNT_W'(1);
            end
          end
          ST_CALC: state <= ST_PEND;
          ST_PEND: if (active) begin
            lineCnt <= '0;
            state   <= ST_WAIT;
          end
          ST_WAIT: if (lineEnd) begin
            if (lineCnt == waitLines) state <= ST_AVG;
            else lineCnt <= lineCnt + WAIT_W'(1);
          end
          default: state <= ST_AVG;
        endcase
      end
    end
  end

  // R2: a sample is only taken with a valid pixel and the strobe at its programmed level
  assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |-> (pixValid && (calStrobe == calPolarity)));

  // R8: the edge that applies an update is never followed by a sample
  assert_no_sample_after_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.apply |=> !ctl.accept);

  // R9: manual mode halts sampling
  assert_manual_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
    manualMode |-> !ctl.accept && !ctl.apply);
endmodule

// File: rtl/blackcal_datapath.sv
module blackcal_datapath
  import blackcal_pkg::*;
#(
  parameter int ADC_W    = 12,
  parameter int AVG_W    = 3,
  parameter int COARSE_W = 9,
  parameter int FINE_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  calCtl_t             ctl,
  input  logic [ADC_W-1:0]    pixData,
  input  logic [ADC_W-1:0]    clipCeiling,
  input  logic [ADC_W-1:0]    targetLevel,
  input  logic [ADC_W-1:0]    coarseThresh,
  input  logic [AVG_W-1:0]    avgSel,
  input  logic [COARSE_W-1:0] manCoarse,
  input  logic [FINE_W-1:0]   manFine,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [FINE_W-1:0]   fineCode
);
  localparam int MAX_SHIFT = (1 << AVG_W) - 1 + 3;
  localparam int SUM_W     = ADC_W + MAX_SHIFT;
  localparam int DIFF_W    = ADC_W + 1;
  localparam int EXT_W     = ((FINE_W > DIFF_W) ? FINE_W : DIFF_W) + 2;
  localparam logic [COARSE_W-1:0] COARSE_MID = COARSE_W'(1) << (COARSE_W - 1);
  localparam logic [FINE_W-1:0]   FINE_MID   = FINE_W'(1) << (FINE_W - 1);

  logic [ADC_W-1:0]         clipped;
  logic [SUM_W-1:0]         sumReg;
  logic [ADC_W-1:0]         avgVal;
  logic signed [DIFF_W-1:0] diff;
  logic [DIFF_W-1:0]        mag;
  logic signed [DIFF_W-1:0] quarter;
  logic [EXT_W-1:0]         fineExt;
  logic                     useCoarse;
  logic                     diffPos;
  logic [COARSE_W-1:0]      coarseNext, pendCoarse;
  logic [FINE_W-1:0]        fineNext, pendFine;

  assign clipped = (pixData > clipCeiling) ? clipCeiling : pixData;
  assign avgVal  = ADC_W'(sumReg >> (32'(avgSel) + 32'd3));
  assign diff    = $signed({1'b0, avgVal}) - $signed({1'b0, targetLevel});
  assign diffPos = !diff[DIFF_W-1] && (diff != '0);
  assign mag     = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
  assign useCoarse = (diff != '0) && (mag >= {1'b0, coarseThresh});
  assign quarter = diff >>> 2;
  assign fineExt = {{(EXT_W-FINE_W){1'b0}}, fineCode}
                 - {{(EXT_W-DIFF_W){quarter[DIFF_W-1]}}, quarter};

  always_comb begin
    coarseNext = coarseCode;
    fineNext   = fineCode;
    if (useCoarse) begin
      if (diffPos) coarseNext = (coarseCode == '0) ? '0 : coarseCode - COARSE_W'(1);
      else         coarseNext = (&coarseCode) ? coarseCode : coarseCode + COARSE_W'(1);
    end else if (fineExt[EXT_W-1]) begin
      fineNext = '0;
    end else if (|fineExt[EXT_W-2:FINE_W]) begin
      fineNext = '1;
    end else begin
      fineNext = fineExt[FINE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg     <= '0;
      pendCoarse <= COARSE_MID;
      pendFine   <= FINE_MID;
      coarseCode <= COARSE_MID;
      fineCode   <= FINE_MID;
    end else begin
      if (ctl.clearSum)    sumReg <= '0;
      else if (ctl.accept) sumReg <= sumReg + SUM_W'(clipped);
      if (ctl.latchPend) begin
        pendCoarse <= coarseNext;
        pendFine   <= fineNext;
      end
      if (ctl.loadManual) begin
        coarseCode <= manCoarse;
        fineCode   <= manFine;
      end else if (ctl.apply) begin
        coarseCode <= pendCoarse;
        fineCode   <= pendFine;
      end
    end
  end

  // R10: codes hold unless an update or a manual load is issued
  assert_codes_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.apply && !ctl.loadManual) |=> ($stable(coarseCode) && $stable(fineCode)));

  // R9: manual load copies the register values
  assert_manual_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadManual |=> (coarseCode == $past(manCoarse)) && (fineCode == $past(manFine)));

  // R5 / R6: one update moves at most one of the two codes
  assert_single_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.apply && !ctl.loadManual) |=> ((coarseCode == $past(coarseCode)) || (fineCode == $past(fineCode))));

  // R3: a clipped sample never exceeds the ceiling
  assert_clip_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accept |-> (clipped <= clipCeiling));
endmodule

// File: rtl/blackLevelServo.sv
module blackLevelServo
  import blackcal_pkg::*;
#(
  parameter int ADC_W    = 12,
  parameter int AVG_W    = 3,
  parameter int WAIT_W   = 12,
  parameter int COARSE_W = 9,
  parameter int FINE_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pixValid,
  input  logic [ADC_W-1:0]    pixData,
  input  logic                calStrobe,
  input  logic                calPolarity,
  input  logic                manualMode,
  input  logic [COARSE_W-1:0] manCoarse,
  input  logic [FINE_W-1:0]   manFine,
  input  logic [AVG_W-1:0]    avgSel,
  input  logic [WAIT_W-1:0]   waitLines,
  input  logic [ADC_W-1:0]    clipCeiling,
  input  logic [ADC_W-1:0]    targetLevel,
  input  logic [ADC_W-1:0]    coarseThresh,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [FINE_W-1:0]   fineCode
);
  calCtl_t ctl;

  blackcal_ctrl #(.AVG_W(AVG_W), .WAIT_W(WAIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .calStrobe(calStrobe), .calPolarity(calPolarity),
    .pixValid(pixValid), .manualMode(manualMode), .avgSel(avgSel),
    .waitLines(waitLines), .ctl(ctl)
  );

  blackcal_datapath #(.ADC_W(ADC_W), .AVG_W(AVG_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixData(pixData), .clipCeiling(clipCeiling),
    .targetLevel(targetLevel), .coarseThresh(coarseThresh), .avgSel(avgSel),
    .manCoarse(manCoarse), .manFine(manFine), .coarseCode(coarseCode), .fineCode(fineCode)
  );

  // R7: outside manual mode, codes only change on an edge where the strobe was active
  assert_update_in_black_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((!$stable(coarseCode) || !$stable(fineCode)) && !$past(manualMode))
      |-> $past(calStrobe == calPolarity));
endmodule

// File: tb/tb_blackLevelServo.sv
module tb_blackLevelServo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [11:0] pixData = '0;
  logic        calStrobe = 1'b1;
  logic        calPolarity = 1'b0;
  logic        manualMode = 1'b0;
  logic [8:0]  manCoarse = '0;
  logic [9:0]  manFine = '0;
  logic [2:0]  avgSel = '0;
  logic [11:0] waitLines = '0;
  logic [11:0] clipCeiling = 12'd4095;
  logic [11:0] targetLevel = 12'd64;
  logic [11:0] coarseThresh = 12'd48;
  logic [8:0]  coarseCode;
  logic [9:0]  fineCode;

  always #5 clk = ~clk;

  blackLevelServo dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .calStrobe(calStrobe), .calPolarity(calPolarity), .manualMode(manualMode),
    .manCoarse(manCoarse), .manFine(manFine), .avgSel(avgSel), .waitLines(waitLines),
    .clipCeiling(clipCeiling), .targetLevel(targetLevel), .coarseThresh(coarseThresh),
    .coarseCode(coarseCode), .fineCode(fineCode)
  );

  int nChecks = 0;
  int nFails  = 0;

  // configuration applied at the next drive point
  int cManual = 0, cPol = 0, cAvg = 0, cWait = 0;
  int cTarget = 64, cThresh = 48, cClip = 4095, cManC = 0, cManF = 0;

  // reference model, stepped once per rising edge
  int mState = 0;      // 0 sample, 1 compute, 2 hold, 3 skip lines
  int mCnt = 0, mSum = 0, mLine = 0, mPrevAct = 0;
  int expC = 256, expF = 512, pendC = 256, pendF = 512;

  task automatic computeNext();
    int avg, diff, mag, q, f;
    avg  = mSum >> (cAvg + 3);
    diff = avg - cTarget;
    mag  = (diff < 0) ? -diff : diff;
    pendC = expC;
    pendF = expF;
    if (diff != 0 && mag >= cThresh) begin
      if (diff > 0) pendC = (expC == 0) ? 0 : expC - 1;
      else          pendC = (expC == 511) ? 511 : expC + 1;
    end else begin
      q = (diff >= 0) ? diff / 4 : -((-diff + 3) / 4);
      f = expF - q;
      pendF = (f < 0) ? 0 : ((f > 1023) ? 1023 : f);
    end
  endtask

  task automatic modelStep(input int act, input int valid, input int data);
    int lineEnd;
    lineEnd  = (mPrevAct == 1 && act == 0) ? 1 : 0;
    mPrevAct = act;
    if (cManual != 0) begin
      mState = 0; mCnt = 0; mSum = 0; mLine = 0;
      expC = cManC; expF = cManF;
      return;
    end
    case (mState)
      0: if (act != 0 && valid != 0) begin
        mSum += (data > cClip) ? cClip : data;
        mCnt++;
        if (mCnt >= (1 << (cAvg + 3))) begin mCnt = 0; mState = 1; end
      end
      1: begin computeNext(); mState = 2; end
      2: if (act != 0) begin expC = pendC; expF = pendF; mSum = 0; mLine = 0; mState = 3; end
      default: if (lineEnd != 0) begin
        if (mLine == cWait) mState = 0;
        else mLine++;
      end
    endcase
  endtask

  task automatic cyc(input int act, input int valid, input int data);
    @(negedge clk);
    manualMode   = (cManual != 0);
    calPolarity  = cPol[0];
    calStrobe    = (cPol != 0) ? act[0] : ~act[0];
    avgSel       = 3'(cAvg);
    waitLines    = 12'(cWait);
    targetLevel  = 12'(cTarget);
    coarseThresh = 12'(cThresh);
    clipCeiling  = 12'(cClip);
    manCoarse    = 9'(cManC);
    manFine      = 10'(cManF);
    pixValid     = valid[0];
    pixData      = 12'(data);
    modelStep(act, valid, data);
  endtask

  task automatic compare(input string tag);
    nChecks++;
    if (coarseCode != 9'(expC)) begin
      nFails++;
      $display("FAIL %s coarse: actual %0d expected %0d", tag, coarseCode, expC);
    end
    nChecks++;
    if (fineCode != 10'(expF)) begin
      nFails++;
      $display("FAIL %s fine: actual %0d expected %0d", tag, fineCode, expF);
    end
  endtask

  // one strobe interval: k active pixels, then a gap with out-of-strobe noise pixels
  task automatic runLine(input int k, input int base, input int step, input int skip, input string tag);
    for (int i = 0; i < k; i++) begin
      if (skip > 0 && (i % skip) == skip - 1) cyc(1, 0, 4095);
      else cyc(1, 1, base + (i * step) % 11);
    end
    for (int g = 0; g < 4; g++) cyc(0, 1, 4095);
    @(negedge clk);
    compare(tag);
    manualMode = manualMode;
    modelStep(0, 1, 4095);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 reset");
    modelStep(0, 0, 0);

    // R6 zero error, then directed errors around the threshold
    runLine(12, 64, 0, 0, "R6 zero error");
    begin
      int lv[8] = '{63, 65, 69, 59, 112, 111, 16, 17};
      for (int i = 0; i < 8; i++) runLine(12, lv[i], 0, 0, "R6/R5 directed level");
    end
    // R4 sweep over black levels with ripple
    for (int b = 0; b < 31; b++) runLine(12, b * 9, 3, 0, "R4 level sweep");
    // R3 clipping
    cClip = 100;
    runLine(12, 4000, 0, 0, "R3 all clipped");
    runLine(12, 95, 5, 0, "R3 partly clipped");
    cClip = 4095;
    // R2 masked pixels and opposite polarity
    runLine(14, 80, 2, 3, "R2 masked pixels");
    cPol = 1;
    runLine(12, 40, 4, 0, "R2 polarity high");
    runLine(12, 90, 1, 0, "R2 polarity high");
    cPol = 0;
    // R4 averaging across lines
    cAvg = 1;
    for (int i = 0; i < 4; i++) runLine(12, 30 + i * 20, 3, 0, "R4 span lines");
    cAvg = 2;
    for (int i = 0; i < 6; i++) runLine(12, 100 - i * 10, 2, 0, "R4 span lines");
    cAvg = 0;
    // R7 update held to the next black interval
    for (int i = 0; i < 3; i++) runLine(8, 20, 1, 0, "R7 held update");
    for (int i = 0; i < 3; i++) runLine(9, 110, 1, 0, "R7 held update");
    for (int i = 0; i < 3; i++) runLine(10, 70, 1, 0, "R7 in-line update");
    // R8 skipped lines
    cWait = 2;
    for (int i = 0; i < 8; i++) runLine(12, 20 + i * 30, 1, 0, "R8 wait lines");
    cWait = 1;
    for (int i = 0; i < 4; i++) runLine(12, 150, 1, 0, "R8 wait lines");
    cWait = 0;
    // R9 manual loads, R5 and R6 saturation
    cManual = 1; cManC = 0; cManF = 1020;
    runLine(12, 300, 0, 0, "R9 manual load");
    cManC = 511;
    runLine(12, 5, 0, 0, "R9 manual load");
    cManC = 0;
    runLine(12, 5, 0, 0, "R9 manual load");
    cManual = 0;
    runLine(12, 300, 0, 0, "R5 coarse floor");
    cManual = 1; cManC = 511;
    runLine(12, 64, 0, 0, "R9 manual load");
    cManual = 0;
    runLine(12, 5, 0, 0, "R5 coarse ceiling");
    cManual = 1; cManC = 5; cManF = 1020;
    runLine(12, 64, 0, 0, "R9 manual load");
    cManual = 0;
    runLine(12, 24, 0, 0, "R6 fine ceiling");
    cManual = 1; cManF = 2; cThresh = 200;
    runLine(12, 64, 0, 0, "R9 manual load");
    cManual = 0;
    runLine(12, 120, 0, 0, "R6 fine floor");
    runLine(12, 64, 0, 0, "R10 hold");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule